// File: doc/BRIEF.md
# Receive Sample Gain-Shift and Byte Packer

This block sits on a receive datapath between a set of per-channel 16-bit signed sample registers and the write port of a 16-bit FIFO. Each sample strobe starts one pass over the active channels. The pass produces FIFO writes in channel order and pauses whenever the FIFO reports full.

In wide mode, each FIFO word carries one channel's complete sample, unchanged. In narrow mode, each sample first goes through a left-shift gain stage. This stage keeps the sign and clips to the largest positive or negative value when the result would overflow. Only the upper byte of the result is kept. Two neighbouring channels share one FIFO word, which halves the bandwidth the receive stream needs. Each shift step doubles the amplitude, about 6 dB. This lets a weak input reach the retained byte instead of reading as zero.

The width mode is one control bit and the gain is a 3-bit shift amount. A change of the width mode abandons any pass in progress. As a result, a word that mixes the two formats is never written.

Top module: `rx_sample_packer`

## Requirements
- R1: During and after a synchronous reset, the block is idle: `fifo_we` is low and `fifo_wdata` reads 0xFFFF until a strobe starts a pass.
- R2: In wide mode (`narrow_en`=0), a `smp_stb` seen while idle, with `chan_count` from 1 to 8, produces exactly `chan_count` writes. The writes carry channels 0, 1, 2, … in that order, each as the full 16-bit sample, and `gain_shift` has no effect.
- R3: In narrow mode (`narrow_en`=1), with an even `chan_count` from 2 to 8, a strobe produces `chan_count`/2 writes. Write k carries channel 2k in bits 7:0 and channel 2k+1 in bits 15:8.
- R4: In narrow mode, each byte placed in a word is bits 15:8 of that channel's gain-adjusted sample. The lower 8 bits are dropped.
- R5: The gain adjustment multiplies the signed sample by 2^`gain_shift` (`gain_shift` from 0 to 7). A result above 32767 becomes 0x7FFF and a result below −32768 becomes 0x8000.
- R6: While `fifo_full` is high, `fifo_we` stays low and the pass holds its position. No word is lost or repeated.
- R7: A strobe that arrives while a pass is in progress is ignored, so no extra words are written.
- R8: A change of `narrow_en` suppresses the write in the cycle it is seen and returns the block to idle. No further word is written until a new strobe.
- R9: If the pass position falls outside the range the current `chan_count` and mode allow, `fifo_wdata` reads 0xFFFF, `fifo_we` stays low, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | New set of channel samples is ready |
| fifo_full | input | 1 | FIFO cannot accept a write |
| chan_count | input | 4 | Number of active channels |
| narrow_en | input | 1 | 1 selects packed byte mode, 0 selects full-sample mode |
| gain_shift | input | 3 | Left-shift amount applied in narrow mode |
| ch_samples | input | 128 | Channel samples, channel n in bits 16n+15:16n |
| fifo_wdata | output | 16 | FIFO write data |
| fifo_we | output | 1 | FIFO write enable |

## Verification
A sequencer stuck at a wrong position shows at the ports within the same cycle. It appears as a word from the wrong channel, or as 0xFFFF with no write strobe. A sequencer that steps by the wrong amount shows as a missing or extra word once the pass completes, a few cycles after the strobe. The scoreboard catches both: it holds the expected words of each pass in order and compares every write as it occurs. It also flags any write it does not expect, which exposes ignored-strobe and mode-change faults on the next clock.

// File: rtl/rxpk_pkg.sv
`timescale 1ns/1ps
package rxpk_pkg;
    localparam int unsigned CH_MAX_DEF = 8;
    localparam int unsigned SMP_W_DEF  = 16;
    localparam int unsigned SH_W_DEF   = 3;

    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } width_mode_e;
endpackage

// File: rtl/rxpk_gain.sv
`timescale 1ns/1ps
module rxpk_gain #(
    parameter int unsigned SMP_W = rxpk_pkg::SMP_W_DEF,
    parameter int unsigned SH_W  = rxpk_pkg::SH_W_DEF
) (
    input  logic [SMP_W-1:0] din,
    input  logic [SH_W-1:0]  shamt,
    output logic [SMP_W-1:0] dout
);
    localparam int unsigned MAXSH = (1 << SH_W) - 1;
    localparam int unsigned WIDE  = SMP_W + MAXSH;

    logic [WIDE-1:0]  wide_v;
    logic [MAXSH:0]   head_v;

    always_comb begin
        wide_v = {{MAXSH{din[SMP_W-1]}}, din} << shamt;
        head_v = wide_v[WIDE-1:SMP_W-1];
        if ((&head_v) || !(|head_v)) begin
            dout = wide_v[SMP_W-1:0];
        end else if (din[SMP_W-1]) begin
            dout = {1'b1, {(SMP_W-1){1'b0}}};
        end else begin
            dout = {1'b0, {(SMP_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/rxpk_seq.sv
`timescale 1ns/1ps
module rxpk_seq #(
    parameter int unsigned CH_MAX = rxpk_pkg::CH_MAX_DEF,
    parameter int unsigned SEQ_W  = $clog2(CH_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             full,
    input  logic [SEQ_W-1:0] nch,
    input  logic             narrow_in,
    output logic [SEQ_W-1:0] pos,
    output logic             narrow_o,
    output logic             valid,
    output logic             we
);
    import rxpk_pkg::*;

    localparam logic [SEQ_W-1:0] CH_MAX_V = SEQ_W'(CH_MAX);
    localparam logic [SEQ_W-1:0] ONE_V    = SEQ_W'(1);
    localparam logic [SEQ_W-1:0] TWO_V    = SEQ_W'(2);

    typedef struct packed {
        logic [SEQ_W-1:0] pos;
        width_mode_e      mode;
    } seq_t;

    seq_t             st_d, st_q;
    logic             mode_chg_d;
    logic             cnt_ok_d;
    logic             valid_d;
    logic [SEQ_W-1:0] last_d;
    logic [SEQ_W-1:0] step_d;

    always_comb begin
        mode_chg_d = (st_q.mode != width_mode_e'(narrow_in));
        if (st_q.mode == MODE_NARROW) begin
            last_d   = nch - ONE_V;
            step_d   = TWO_V;
            cnt_ok_d = (nch >= TWO_V) && (nch <= CH_MAX_V);
        end else begin
            last_d   = nch;
            step_d   = ONE_V;
            cnt_ok_d = (nch >= ONE_V) && (nch <= CH_MAX_V);
        end
        valid_d = (st_q.pos != '0) && (st_q.pos <= last_d) && cnt_ok_d
                  && ((st_q.mode == MODE_WIDE) || st_q.pos[0]);

        st_d      = st_q;
        st_d.mode = width_mode_e'(narrow_in);
        if (mode_chg_d) begin
            st_d.pos = '0;
        end else if (st_q.pos == '0) begin
            if (strobe && cnt_ok_d) begin
                st_d.pos = ONE_V;
            end
        end else if (!valid_d) begin
            st_d.pos = '0;
        end else if (!full) begin
            st_d.pos = (st_q.pos >= last_d) ? '0 : st_q.pos + step_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pos: '0, mode: width_mode_e'(narrow_in)};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos      = st_q.pos;
    assign narrow_o = (st_q.mode == MODE_NARROW);
    assign valid    = valid_d;
    assign we       = valid_d && !full && !mode_chg_d;
endmodule

// File: rtl/rx_sample_packer.sv
`timescale 1ns/1ps
module rx_sample_packer #(
    parameter int unsigned CH_MAX = rxpk_pkg::CH_MAX_DEF,
    parameter int unsigned SMP_W  = rxpk_pkg::SMP_W_DEF,
    parameter int unsigned SH_W   = rxpk_pkg::SH_W_DEF,
    localparam int unsigned SEQ_W = $clog2(CH_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_stb,
    input  logic                    fifo_full,
    input  logic [SEQ_W-1:0]        chan_count,
    input  logic                    narrow_en,
    input  logic [SH_W-1:0]         gain_shift,
    input  logic [CH_MAX*SMP_W-1:0] ch_samples,
    output logic [SMP_W-1:0]        fifo_wdata,
    output logic                    fifo_we
);
    localparam int unsigned SEL_W  = $clog2(CH_MAX);
    localparam int unsigned BYTE_W = SMP_W / 2;

    logic [SMP_W-1:0]  smp    [CH_MAX];
    logic [SMP_W-1:0]  gsmp   [CH_MAX];
    logic [BYTE_W-1:0] nbyte  [CH_MAX];
    logic [SEQ_W-1:0]  seq_state;
    logic              narrow_q;
    logic              seq_valid;
    logic [SEL_W-1:0]  sel_d, sel_even_d, sel_odd_d;

    for (genvar g = 0; g < CH_MAX; g++) begin : g_ch
        assign smp[g] = ch_samples[g*SMP_W +: SMP_W];
        rxpk_gain #(.SMP_W(SMP_W), .SH_W(SH_W)) u_gain (
            .din   (smp[g]),
            .shamt (gain_shift),
            .dout  (gsmp[g])
        );
        assign nbyte[g] = gsmp[g][SMP_W-1 -: BYTE_W];
    end

    rxpk_seq #(.CH_MAX(CH_MAX), .SEQ_W(SEQ_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (smp_stb),
        .full      (fifo_full),
        .nch       (chan_count),
        .narrow_in (narrow_en),
        .pos       (seq_state),
        .narrow_o  (narrow_q),
        .valid     (seq_valid),
        .we        (fifo_we)
    );

    always_comb begin
        sel_d      = SEL_W'(seq_state - SEQ_W'(1));
        sel_even_d = {sel_d[SEL_W-1:1], 1'b0};
        sel_odd_d  = {sel_d[SEL_W-1:1], 1'b1};
        if (!seq_valid) begin
            fifo_wdata = '1;
        end else if (narrow_q) begin
            fifo_wdata = {nbyte[sel_odd_d], nbyte[sel_even_d]};
        end else begin
            fifo_wdata = smp[sel_d];
        end
    end
endmodule

// File: rtl/rxpk_chk.sv
`timescale 1ns/1ps
module rxpk_chk #(
    parameter int unsigned SEQ_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_full,
    input logic             fifo_we,
    input logic             narrow_en,
    input logic [SEQ_W-1:0] chan_count,
    input logic [SEQ_W-1:0] seq_state
);
    assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (rst)
        (seq_state == '0) |-> !fifo_we);

    assert_no_write_full_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fifo_we);

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && seq_state != '0) |=>
        (seq_state == $past(seq_state) || seq_state == '0));

    assert_pair_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_we && narrow_en) |-> seq_state[0]);

    assert_mode_change_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (narrow_en != $past(narrow_en)) |-> !fifo_we);

    assert_mode_change_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (narrow_en != $past(narrow_en)) |=> (seq_state == '0));

    assert_write_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> (seq_state != '0 && seq_state <= chan_count));
endmodule

bind rx_sample_packer rxpk_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_full  (fifo_full),
    .fifo_we    (fifo_we),
    .narrow_en  (narrow_en),
    .chan_count (chan_count),
    .seq_state  (seq_state)
);

// File: tb/sim_rx_sample_packer.sv
`timescale 1ns/1ps
module sim_rx_sample_packer;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_stb = 1'b0;
    logic         fifo_full = 1'b0;
    logic [3:0]   chan_count = 4'd4;
    logic         narrow_en = 1'b0;
    logic [2:0]   gain_shift = 3'd0;
    logic [127:0] ch_samples = '0;
    logic [15:0]  fifo_wdata;
    logic         fifo_we;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    rx_sample_packer u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .fifo_full(fifo_full),
        .chan_count(chan_count), .narrow_en(narrow_en), .gain_shift(gain_shift),
        .ch_samples(ch_samples), .fifo_wdata(fifo_wdata), .fifo_we(fifo_we)
    );

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] smp_of(int i);
        return ch_samples[i*16 +: 16];
    endfunction

    function automatic logic [7:0] model_byte(logic [15:0] v, int sh);
        int x;
        logic [15:0] c;
        x = $signed(v);
        x = x * (1 << sh);
        if (x > 32767) x = 32767;
        if (x < -32768) x = -32768;
        c = x[15:0];
        return c[15:8];
    endfunction

    task automatic push_pass(int nch, bit nar, int sh, string tag);
        if (!nar) begin
            for (int i = 0; i < nch; i++) begin
                exp_q.push_back(smp_of(i));
                tag_q.push_back(tag);
            end
        end else begin
            for (int k = 0; k < nch; k += 2) begin
                exp_q.push_back({model_byte(smp_of(k+1), sh), model_byte(smp_of(k), sh)});
                tag_q.push_back(tag);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst && fifo_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected write", fifo_wdata, 16'hxxxx);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(fifo_wdata === e, t, fifo_wdata, e);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(int gap);
        @(posedge clk); #1 smp_stb = 1'b1;
        @(posedge clk); #1 smp_stb = 1'b0;
        if (gap > 0) cyc(gap);
    endtask

    task automatic drain(string tag);
        cyc(24);
        chk(exp_q.size() == 0, tag, 16'(exp_q.size()), 16'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic load(int base, int step);
        for (int i = 0; i < 8; i++) ch_samples[i*16 +: 16] = 16'(base + i*step);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        @(negedge clk);
        chk(fifo_we == 1'b0, "R1 we in reset", 16'(fifo_we), 16'd0);
        chk(fifo_wdata == 16'hFFFF, "R1 data in reset", fifo_wdata, 16'hFFFF);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(fifo_we == 1'b0, "R1 we after reset", 16'(fifo_we), 16'd0);
        chk(fifo_wdata == 16'hFFFF, "R1 data after reset", fifo_wdata, 16'hFFFF);

        // R2: four channels, gain ignored in wide mode
        load(16'h1234, 16'h1111); gain_shift = 3'd5; chan_count = 4'd4;
        push_pass(4, 0, 5, "R2 wide 4ch");
        pulse(0); drain("R2 wide 4ch count");

        // R2: eight channels, negative values
        load(16'h8001, 16'h2003); chan_count = 4'd8;
        push_pass(8, 0, 5, "R2 wide 8ch");
        pulse(0); drain("R2 wide 8ch count");

        // R3 / R4: narrow, no gain
        narrow_en = 1'b1; gain_shift = 3'd0; cyc(2);
        load(16'hA55A, 16'h0F13);
        push_pass(8, 1, 0, "R3 R4 narrow 8ch");
        pulse(0); drain("R3 narrow 8ch count");

        // R5: shift 3 with clipping both ways
        gain_shift = 3'd3;
        ch_samples[0*16 +: 16] = 16'h0123; ch_samples[1*16 +: 16] = 16'h1000;
        ch_samples[2*16 +: 16] = 16'hF000; ch_samples[3*16 +: 16] = 16'hEFFF;
        ch_samples[4*16 +: 16] = 16'h0FFF; ch_samples[5*16 +: 16] = 16'hFFFF;
        ch_samples[6*16 +: 16] = 16'h00FF; ch_samples[7*16 +: 16] = 16'h8000;
        push_pass(8, 1, 3, "R5 shift3");
        pulse(0); drain("R5 shift3 count");

        // R5: maximum shift, 4 channels
        gain_shift = 3'd7; chan_count = 4'd4;
        ch_samples[0*16 +: 16] = 16'h0040; ch_samples[1*16 +: 16] = 16'h0100;
        ch_samples[2*16 +: 16] = 16'hFFC0; ch_samples[3*16 +: 16] = 16'hFF00;
        push_pass(4, 1, 7, "R5 shift7");
        pulse(0); drain("R5 shift7 count");

        // R3: two channels, single word
        chan_count = 4'd2; gain_shift = 3'd1; load(16'h3F00, 16'h8123);
        push_pass(2, 1, 1, "R3 narrow 2ch");
        pulse(0); drain("R3 narrow 2ch count");

        // R6: stall in narrow mode
        chan_count = 4'd8; load(16'h7700, 16'h1357);
        push_pass(8, 1, 1, "R6 narrow stall");
        pulse(0);
        for (int c = 0; c < 20; c++) begin
            fifo_full = (c % 3) != 0;
            cyc(1);
        end
        fifo_full = 1'b0; drain("R6 narrow stall count");

        // R6: stall in wide mode
        narrow_en = 1'b0; cyc(2); chan_count = 4'd6; load(16'h0102, 16'h0304);
        push_pass(6, 0, 0, "R6 wide stall");
        pulse(0);
        for (int c = 0; c < 24; c++) begin
            fifo_full = (c % 4) < 2;
            cyc(1);
        end
        fifo_full = 1'b0; drain("R6 wide stall count");

        // R7: second strobe mid-pass ignored
        chan_count = 4'd8; load(16'h4000, 16'h0101);
        push_pass(8, 0, 0, "R7 busy strobe");
        pulse(1); pulse(0); drain("R7 busy strobe count");

        // R8: mode change while stalled abandons the pass
        fifo_full = 1'b1; narrow_en = 1'b1; chan_count = 4'd4; cyc(2);
        pulse(2);
        narrow_en = 1'b0; fifo_full = 1'b0;
        @(negedge clk);
        chk(fifo_we == 1'b0, "R8 write on change", 16'(fifo_we), 16'd0);
        drain("R8 nothing after change");
        chan_count = 4'd2; load(16'h0A0B, 16'h0C0D);
        push_pass(2, 0, 0, "R8 recovery");
        pulse(0); drain("R8 recovery count");

        // R9: position out of range drives 0xFFFF and goes idle
        fifo_full = 1'b1; chan_count = 4'd4;
        pulse(2);
        chan_count = 4'd0;
        @(negedge clk);
        chk(fifo_wdata == 16'hFFFF, "R9 out-of-range data", fifo_wdata, 16'hFFFF);
        chk(fifo_we == 1'b0, "R9 out-of-range we", 16'(fifo_we), 16'd0);
        cyc(2); chan_count = 4'd4; fifo_full = 1'b0;
        drain("R9 idle after range fault");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule